// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes into asynchronous serial frames. The frame format is set by three fields: character length, parity mode and stop-bit count. It can also drive a break condition on the line. A producer offers a byte through a valid/ready handshake into a one-entry holding register. An external baud generator supplies a full-bit tick and a half-bit tick. The block shifts out a low start bit, then the data bits least significant first, then an optional parity bit, then high stop bits.

Break commands arrive as single-cycle pulses. A start command drives the line low, and it is accepted only when nothing is held or shifting. A stop command ends the break and holds the line high for a guard interval of twelve bit ticks. Queued characters go out after that interval. The format fields are captured when a frame launches, so a field change made during a frame applies from the next frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line output is high, the active flag is 0, the empty flag is 1 and the ready output is 1.
- R2: A frame begins with one low start bit, followed by the data bits least significant first. The character-length field selects the data width: 0 or 1 gives 8 bits, 2 gives 7 bits and 3 gives 6 bits.
- R3: The parity field selects the parity bit, which follows the data. Value 0 gives even parity (the parity bit makes the total count of ones even), 1 gives odd parity, 2 gives a constant 0 and 3 gives a constant 1. Values 4 to 7 send no parity bit.
- R4: Stop bits are high. Stop field 0 gives 2 half-bit periods of stop, 1 gives 3 and 2 gives 4. Value 3 is reserved and gives 2. The active flag stays high for exactly (2·(1+data bits+parity bits)+stop halves) half-bit tick periods.
- R5: The format fields are sampled when a frame launches. A change made while a frame is shifting does not alter that frame and applies to the next one.
- R6: A break start pulse takes effect only when the empty flag is 1. It then holds the line low with the active flag 0. While a character is held or a frame is shifting, the pulse is ignored.
- R7: A break stop pulse overrides a simultaneous start pulse. After a break, the line stays high for the next 12 bit ticks before a held character may launch.
- R8: The active flag is 1 exactly while a frame shifts. The empty flag is 1 only when nothing is held and the block is idle.
- R9: Ready drops for the cycle after a byte is accepted. With the enable low, a held byte does not launch. It launches on a half-bit tick once the enable returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Permits new frames to launch |
| bit_tick | input | 1 | One pulse per bit period |
| half_tick | input | 1 | One pulse per half bit period |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Holding register free |
| char_len | input | 2 | Data width select |
| par_mode | input | 3 | Parity select |
| stop_mode | input | 2 | Stop-bit count select |
| brk_start | input | 1 | Break start command pulse |
| brk_stop | input | 1 | Break stop command pulse |
| txd | output | 1 | Serial line |
| tx_active | output | 1 | Frame shifting |
| tx_empty | output | 1 | Nothing held and idle |

## Verification
The hardest case to reach is the end of a break while a character is already waiting. That character must sit through the whole guard interval, and during the break the stop pulse is driven together with a start pulse. The bench gets there by opening a break from the idle state, loading a byte while the line is low, and then pulsing both commands at once. It measures the cycles until the held frame's active flag rises. Mid-frame changes to the format fields are made one cycle after launch, and the next frame then checks that the new format applies.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W = 8;
  localparam int NB_W   = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK, S_GUARD
  } tx_state_t;

  typedef struct packed {
    logic [NB_W-1:0] nbits;
    logic            par_en;
    logic            par_bit;
    logic [2:0]      stop_halves;
  } tx_fmt_t;
endpackage

// File: rtl/txf_fmt_decode.sv
module txf_fmt_decode
  import uart_tx_pkg::*;
(
  input  logic [1:0]        char_len,
  input  logic [2:0]        par_mode,
  input  logic [1:0]        stop_mode,
  input  logic [DATA_W-1:0] raw,
  output tx_fmt_t           fmt,
  output logic [DATA_W-1:0] data
);
  logic [NB_W-1:0]   nb;
  logic [DATA_W-1:0] mask;

  always_comb begin
    case (char_len)
      2'd2:    nb = NB_W'(DATA_W - 1);
      2'd3:    nb = NB_W'(DATA_W - 2);
      default: nb = NB_W'(DATA_W);
    endcase
    mask = {DATA_W{1'b1}} >> (NB_W'(DATA_W) - nb);
    data = raw & mask;
    fmt.nbits  = nb;
    fmt.par_en = !par_mode[2];
    case (par_mode[1:0])
      2'd0: fmt.par_bit = ^data;
      2'd1: fmt.par_bit = ~^data;
      2'd2: fmt.par_bit = 1'b0;
      default: fmt.par_bit = 1'b1;
    endcase
    case (stop_mode)
      2'd1:    fmt.stop_halves = 3'd3;
      2'd2:    fmt.stop_halves = 3'd4;
      default: fmt.stop_halves = 3'd2;
    endcase
  end
endmodule

// File: rtl/txf_guard_timer.sv
module txf_guard_timer #(
  parameter int GUARD_BITS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bit_tick,
  output logic done
);
  localparam int GW = $clog2(GUARD_BITS + 1);
  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= GW'(GUARD_BITS);
    else if (clear)
      cnt <= '0;
    else if (bit_tick && cnt != GW'(GUARD_BITS))
      cnt <= cnt + 1'b1;
  end

  assign done = (cnt == GW'(GUARD_BITS));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int GUARD_BITS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              bit_tick,
  input  logic              half_tick,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        char_len,
  input  logic [2:0]        par_mode,
  input  logic [1:0]        stop_mode,
  input  logic              brk_start,
  input  logic              brk_stop,
  output logic              txd,
  output logic              tx_active,
  output logic              tx_empty
);
  tx_state_t         state;
  tx_fmt_t           fmt_d, fmt_q;
  logic [DATA_W-1:0] data_d, shift, hold_data;
  logic              hold_full, ph, guard_clr, guard_done, launch, last_stop;
  logic [NB_W-1:0]   bcnt;
  logic [2:0]        scnt;

  txf_fmt_decode u_dec (
    .char_len (char_len), .par_mode (par_mode), .stop_mode (stop_mode),
    .raw (hold_data), .fmt (fmt_d), .data (data_d)
  );

  assign guard_clr = (state == S_BRK) && brk_stop;

  txf_guard_timer #(.GUARD_BITS(GUARD_BITS)) u_guard (
    .clk (clk), .rst (rst), .clear (guard_clr),
    .bit_tick (bit_tick), .done (guard_done)
  );

  assign last_stop = (state == S_STOP) && (scnt == fmt_q.stop_halves - 3'd1);
  assign launch    = hold_full && en && half_tick &&
                     ((state == S_IDLE) || last_stop);
  assign in_ready  = !hold_full;
  assign tx_empty  = !hold_full && (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      txd       <= 1'b1;
      tx_active <= 1'b0;
      hold_full <= 1'b0;
      hold_data <= '0;
      shift     <= '0;
      fmt_q     <= '0;
      ph        <= 1'b0;
      bcnt      <= '0;
      scnt      <= '0;
    end else begin
      if (in_valid && !hold_full) begin
        hold_full <= 1'b1;
        hold_data <= in_data;
      end
      case (state)
        S_IDLE: begin
          if (!brk_stop && brk_start && !hold_full) begin
            state <= S_BRK;
            txd   <= 1'b0;
          end
        end
        S_START: begin
          if (half_tick) begin
            ph <= !ph;
            if (ph) begin
              state <= S_DATA;
              txd   <= shift[0];
              bcnt  <= '0;
            end
          end
        end
        S_DATA: begin
          if (half_tick) begin
            ph <= !ph;
            if (ph) begin
              if (bcnt == fmt_q.nbits - 1'b1) begin
                scnt <= '0;
                if (fmt_q.par_en) begin
                  state <= S_PAR;
                  txd   <= fmt_q.par_bit;
                end else begin
                  state <= S_STOP;
                  txd   <= 1'b1;
                end
              end else begin
                shift <= shift >> 1;
                txd   <= shift[1];
                bcnt  <= bcnt + 1'b1;
              end
            end
          end
        end
        S_PAR: begin
          if (half_tick) begin
            ph <= !ph;
            if (ph) begin
              state <= S_STOP;
              txd   <= 1'b1;
              scnt  <= '0;
            end
          end
        end
        S_STOP: begin
          if (half_tick) begin
            if (last_stop) begin
              state     <= S_IDLE;
              tx_active <= 1'b0;
            end else begin
              scnt <= scnt + 3'd1;
            end
          end
        end
        S_BRK: begin
          if (brk_stop) begin
            state <= S_GUARD;
            txd   <= 1'b1;
          end
        end
        S_GUARD: begin
          if (guard_done) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (launch) begin
        state     <= S_START;
        txd       <= 1'b0;
        tx_active <= 1'b1;
        ph        <= 1'b0;
        fmt_q     <= fmt_d;
        shift     <= data_d;
        hold_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic txd,
  input logic tx_active,
  input logic tx_empty,
  input logic in_ready,
  input logic in_valid,
  input logic brk_stop
);
  assert_active_not_empty_R8: assert property (@(posedge clk) disable iff (rst)
    tx_active |-> !tx_empty);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_active) |-> !txd);

  assert_stop_high_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_active) |-> txd);

  assert_break_only_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(txd) && !tx_active) |-> $past(tx_empty));

  assert_stop_blocks_start_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && brk_stop) |=> txd);

  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> !in_ready);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk (clk), .rst (rst), .txd (txd), .tx_active (tx_active),
  .tx_empty (tx_empty), .in_ready (in_ready), .in_valid (in_valid),
  .brk_stop (brk_stop)
);

// File: tb/uart_frame_tx_bench.sv
`timescale 1ns/1ps
module uart_frame_tx_bench;
  localparam int H = 4;

  logic clk = 1'b0, rst = 1'b1, en = 1'b1;
  logic bit_tick = 1'b0, half_tick = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] char_len = '0;
  logic [2:0] par_mode = 3'd4;
  logic [1:0] stop_mode = '0;
  logic brk_start = 1'b0, brk_stop = 1'b0;
  logic txd, tx_active, tx_empty;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_frame_tx u_uart_frame_tx (
    .clk (clk), .rst (rst), .en (en), .bit_tick (bit_tick), .half_tick (half_tick),
    .in_data (in_data), .in_valid (in_valid), .in_ready (in_ready),
    .char_len (char_len), .par_mode (par_mode), .stop_mode (stop_mode),
    .brk_start (brk_start), .brk_stop (brk_stop),
    .txd (txd), .tx_active (tx_active), .tx_empty (tx_empty)
  );

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % (2 * H);
      half_tick = (tc % H == 0);
      bit_tick  = (tc == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [1:0] cl);
    return (cl == 2'd2) ? 7 : (cl == 2'd3) ? 6 : 8;
  endfunction

  function automatic int halves_of(input logic [1:0] sm);
    return (sm == 2'd1) ? 3 : (sm == 2'd2) ? 4 : 2;
  endfunction

  function automatic logic exp_bit(input int idx, input logic [7:0] d,
                                   input logic [1:0] cl, input logic [2:0] pm);
    int n = nbits_of(cl);
    logic [7:0] m = d & (8'hFF >> (8 - n));
    if (idx == 0) return 1'b0;
    if (idx <= n) return m[idx-1];
    if (idx == n + 1 && !pm[2]) begin
      case (pm[1:0])
        2'd0: return ^m;
        2'd1: return ~^m;
        2'd2: return 1'b0;
        default: return 1'b1;
      endcase
    end
    return 1'b1;
  endfunction

  task automatic load(input logic [7:0] d);
    int guard = 0;
    while (!in_ready && guard < 2000) begin @(negedge clk); guard++; end
    in_data = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse(input bit s, input bit p);
    brk_start = s; brk_stop = p;
    @(negedge clk);
    brk_start = 1'b0; brk_stop = 1'b0;
  endtask

  // watch one frame; optionally alter the format fields one cycle after launch
  task automatic watch(input logic [7:0] d, input string req, input bit chg,
                       input logic [1:0] ncl, input logic [2:0] npm, input logic [1:0] nsm);
    logic [1:0] cl = char_len;
    logic [2:0] pm = par_mode;
    logic [1:0] sm = stop_mode;
    int n = nbits_of(cl);
    int p = pm[2] ? 0 : 1;
    int nb = 2 + n + p;
    int cyc = 0, wait_c = 0, mism = 0, first_bad = -1;
    while (!tx_active && wait_c < 2000) begin @(negedge clk); wait_c++; end
    while (tx_active && cyc < 400) begin
      if (chg && cyc == 1) begin char_len = ncl; par_mode = npm; stop_mode = nsm; end
      for (int i = 0; i < nb; i++)
        if (cyc == (2 * i + 1) * H - 1 && txd !== exp_bit(i, d, cl, pm)) begin
          mism++;
          if (first_bad < 0) first_bad = i;
        end
      cyc++;
      @(negedge clk);
    end
    check(mism == 0, {req, " frame bits"}, first_bad, -1);
    check(cyc == H * (2 * (1 + n + p) + halves_of(sm)), "R4 frame length",
          cyc, H * (2 * (1 + n + p) + halves_of(sm)));
  endtask

  task automatic frame(input logic [7:0] d, input logic [1:0] cl, input logic [2:0] pm,
                       input logic [1:0] sm, input string req);
    char_len = cl; par_mode = pm; stop_mode = sm;
    load(d);
    watch(d, req, 1'b0, 2'd0, 3'd0, 2'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int gap;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R1 txd", txd, 1);
    check(tx_active === 1'b0, "R1 active", tx_active, 0);
    check(tx_empty === 1'b1, "R1 empty", tx_empty, 1);
    check(in_ready === 1'b1, "R1 ready", in_ready, 1);

    // directed formats
    frame(8'hA5, 2'd0, 3'd4, 2'd0, "R2 8N1");
    frame(8'h3C, 2'd1, 3'd4, 2'd3, "R2 len1 reserved stop");
    frame(8'hD3, 2'd2, 3'd0, 2'd0, "R3 7E1");
    frame(8'hF6, 2'd3, 3'd1, 2'd2, "R3 6O2");
    frame(8'h81, 2'd0, 3'd3, 2'd1, "R3 mark 1.5 stop");
    frame(8'h7E, 2'd0, 3'd2, 2'd0, "R3 space");
    frame(8'h00, 2'd0, 3'd1, 2'd2, "R3 odd zero data");

    // R5: change fields during a frame
    char_len = 2'd0; par_mode = 3'd4; stop_mode = 2'd0;
    load(8'h5A);
    watch(8'h5A, "R5 old format kept", 1'b1, 2'd3, 3'd1, 2'd2);
    load(8'h2B);
    watch(8'h2B, "R5 new format applied", 1'b0, 2'd0, 3'd0, 2'd0);

    // random frames
    for (int k = 0; k < 30; k++)
      frame(8'($urandom), 2'($urandom), 3'($urandom), 2'($urandom), "R2 R3 random");

    // R6: break while shifting is ignored
    char_len = 2'd0; par_mode = 3'd4; stop_mode = 2'd0;
    load(8'hFF);
    while (!tx_active) @(negedge clk);
    repeat (3) @(negedge clk);
    pulse(1'b1, 1'b0);
    while (tx_active) @(negedge clk);
    repeat (20) @(negedge clk);
    check(txd === 1'b1, "R6 break ignored while shifting", txd, 1);

    // R9 + R6: pending byte with enable low, break ignored, no launch
    en = 1'b0;
    load(8'h96);
    check(in_ready === 1'b0, "R9 ready low while held", in_ready, 0);
    check(tx_empty === 1'b0, "R8 not empty while held", tx_empty, 0);
    pulse(1'b1, 1'b0);
    repeat (60) @(negedge clk);
    check(txd === 1'b1 && tx_active === 1'b0, "R9 R6 hold with enable low", txd, 1);
    en = 1'b1;
    watch(8'h96, "R9 launch after enable", 1'b0, 2'd0, 3'd0, 2'd0);

    // R7: simultaneous start and stop while idle leaves the line high
    pulse(1'b1, 1'b1);
    repeat (10) @(negedge clk);
    check(txd === 1'b1, "R7 stop overrides start", txd, 1);

    // R6: break from idle holds the line low
    pulse(1'b1, 1'b0);
    repeat (40) @(negedge clk);
    check(txd === 1'b0, "R6 break low", txd, 0);
    check(tx_active === 1'b0, "R8 break not active", tx_active, 0);
    load(8'hC3);
    repeat (10) @(negedge clk);
    check(txd === 1'b0, "R6 break held with byte queued", txd, 0);

    // R7: stop (with start) ends break, guard before queued frame
    pulse(1'b1, 1'b1);
    gap = 1;
    while (!tx_active && gap < 1000) begin
      if (txd !== 1'b1) begin check(0, "R7 guard high", txd, 1); break; end
      gap++;
      @(negedge clk);
    end
    check(gap >= 2 * H * 11 && gap <= 2 * H * 12 + H + 4, "R7 guard length", gap, 2 * H * 12);
    watch(8'hC3, "R7 frame after guard", 1'b0, 2'd0, 3'd0, 2'd0);
    repeat (5) @(negedge clk);
    check(tx_empty === 1'b1, "R8 empty after all frames", tx_empty, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule